// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block is the slave-side front end of a small serial flash model. It watches a mode-0 serial bus (clock idles low, input bits taken on the rising clock edge with the most significant bit first, output bits changed on the falling edge). It identifies the command byte that opens each chip-select frame and then walks through the address, dummy and data bytes that this command calls for, always counting in whole bytes of eight clocks. A back end receives the decoded command, the assembled address and a strobe for every completed byte, tagged with the phase that byte belonged to. Incoming data bytes for program commands come with that strobe.

For commands that return data, the block drives a continuous output stream for as long as the bus master keeps clocking. Each output byte is requested from the back end through a one-cycle request and a byte input. The identification read is the exception: it produces its two identity bytes internally, beginning with the one that address bit 0 selects and then alternating. Raising chip-select ends a frame at any point. A command byte that is not recognised silences the block for the rest of that frame.

The serial pins are sampled by a fast system clock, so the serial clock must be several system clocks per half period.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset `miso_oe` is 0, `cmd_o` is 0, and neither `ph_strobe` nor `cmd_valid` has pulsed.
- R2: After the eighth rising serial clock edge of a frame, `cmd_o` takes the command code and `cmd_valid` pulses once. Codes: 03h→1 (read), 0Bh→2 (fast read), 05h→3 (status read), 9Fh→4 (identity-string read), 90h or ABh→5 (ID read), 20h→6 (4 KiB erase), 52h→7 (32 KiB erase), D8h→8 (64 KiB erase), 60h or C7h→9 (full erase), 02h→10 (byte program), ADh→11 (auto-increment program), any other byte→0.
- R3: Commands 1, 2, 5, 6, 7, 8, 10 and 11 take three address bytes, most significant byte first. Each address byte gives one strobe of kind 1. `addr_o` holds the 24-bit address from then until the next address phase.
- R4: Each completed byte that the current command uses gives one `ph_strobe` pulse. `ph_kind` is 0 for the command byte, 1 for an address byte, 2 for the dummy byte and 3 for a data byte.
- R5: Read (1) starts its data phase right after the address. It outputs back-end bytes, most significant bit first, with no limit on their number. Each data byte completed gives one strobe of kind 3.
- R6: Fast read (2) inserts exactly one dummy byte (strobe kind 2) after the address and before its unlimited data stream.
- R7: Status read (3) and identity-string read (4) have no address and no dummy byte. Their first output byte starts on the first clock after the command byte, and bytes continue while clocking goes on.
- R8: ID read (5) outputs identity byte 8'hA5 when address bit 0 is 0 and 8'h3C when it is 1. It then alternates between the two until chip-select rises, and it issues no `rd_req`.
- R9: Erase commands (6 to 9) give no data strobes, and full erase (9) has no address. Byte program (10) accepts one data byte and auto-increment program (11) accepts two, each on `rx_byte` with a strobe of kind 3. Further bytes give no strobe. None of these commands enables `miso_oe`.
- R10: After an unrecognised command byte, `cmd_o` is 0, and no strobe, no `cmd_valid` and no `miso_oe` occur for the rest of the frame.
- R11: A chip-select rise, even in the middle of a byte, ends the frame. `miso_oe` drops, and the next frame starts again at the command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, mode 0 |
| csn | input | 1 | Chip-select, active low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Drive enable for `miso`; 0 means high impedance |
| cmd_o | output | 4 | Decoded command code |
| cmd_valid | output | 1 | One-cycle pulse when a known command byte completes |
| addr_o | output | 24 | Assembled address |
| ph_strobe | output | 1 | One-cycle pulse per completed byte in use |
| ph_kind | output | 2 | Phase of the byte that `ph_strobe` reports |
| rx_byte | output | 8 | Byte just received, valid with `ph_strobe` |
| rd_req | output | 1 | Request for the next output byte |
| rd_byte | input | 8 | Next output byte from the back end, stable by the following falling serial edge |

## Verification
A status or identity-string read decides its command, emits the command strobe, raises `cmd_valid` and arms the first output load in the same system cycle. The output shifter must then present that byte's top bit on the very next falling edge. The bench provokes this with a frame whose command byte is followed directly by output clocks, and judges it by whether the first sampled byte equals the first back-end byte. A second collision is a chip-select rise halfway through a command byte. The bench provokes this with a partial frame and judges it by whether the next frame is decoded cleanly from its first bit.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

   typedef enum logic [3:0] {
      CMD_NONE      = 4'd0,
      CMD_READ      = 4'd1,
      CMD_FREAD     = 4'd2,
      CMD_RDSTAT    = 4'd3,
      CMD_JID       = 4'd4,
      CMD_RDID      = 4'd5,
      CMD_ERS_SEC   = 4'd6,
      CMD_ERS_32K   = 4'd7,
      CMD_ERS_64K   = 4'd8,
      CMD_ERS_ALL   = 4'd9,
      CMD_PROG_BYTE = 4'd10,
      CMD_PROG_AAI  = 4'd11
   } cmd_e;

   typedef enum logic [1:0] {
      PH_OPC   = 2'd0,
      PH_ADDR  = 2'd1,
      PH_DUMMY = 2'd2,
      PH_DATA  = 2'd3
   } phase_e;

   // shape of a frame once the command byte is known
   typedef struct packed {
      logic       has_addr;
      logic       has_dummy;
      logic       streams;
      logic [1:0] in_bytes;
   } shape_t;

   function automatic cmd_e op_decode(input logic [7:0] op);
      case (op)
         8'h03:         return CMD_READ;
         8'h0B:         return CMD_FREAD;
         8'h05:         return CMD_RDSTAT;
         8'h9F:         return CMD_JID;
         8'h90, 8'hAB:  return CMD_RDID;
         8'h20:         return CMD_ERS_SEC;
         8'h52:         return CMD_ERS_32K;
         8'hD8:         return CMD_ERS_64K;
         8'h60, 8'hC7:  return CMD_ERS_ALL;
         8'h02:         return CMD_PROG_BYTE;
         8'hAD:         return CMD_PROG_AAI;
         default:       return CMD_NONE;
      endcase
   endfunction

   function automatic shape_t op_shape(input cmd_e c);
      case (c)
         CMD_READ:      return shape_t'{1'b1, 1'b0, 1'b1, 2'd0};
         CMD_FREAD:     return shape_t'{1'b1, 1'b1, 1'b1, 2'd0};
         CMD_RDSTAT,
         CMD_JID:       return shape_t'{1'b0, 1'b0, 1'b1, 2'd0};
         CMD_RDID:      return shape_t'{1'b1, 1'b0, 1'b1, 2'd0};
         CMD_ERS_SEC,
         CMD_ERS_32K,
         CMD_ERS_64K:   return shape_t'{1'b1, 1'b0, 1'b0, 2'd0};
         CMD_PROG_BYTE: return shape_t'{1'b1, 1'b0, 1'b0, 2'd1};
         CMD_PROG_AAI:  return shape_t'{1'b1, 1'b0, 1'b0, 2'd2};
         default:       return shape_t'{1'b0, 1'b0, 1'b0, 2'd0};
      endcase
   endfunction

endpackage

// File: rtl/fcf_sync_edge.sv
module fcf_sync_edge #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic csn,
   input  logic mosi,
   output logic s_cs,
   output logic s_mosi,
   output logic rise,
   output logic fall
);

   initial begin
      assert (STAGES >= 1 && STAGES <= 3)
         else $error("fcf_sync_edge: STAGES must be 1 to 3");
   end

   logic sck_s;
   logic sck_p;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sck_s  <= 1'b0;
               s_cs   <= 1'b1;
               s_mosi <= 1'b0;
            end else begin
               sck_s  <= sck;
               s_cs   <= csn;
               s_mosi <= mosi;
            end
         end
      end else begin : g_multi
         logic [STAGES-1:0] sck_pipe;
         logic [STAGES-1:0] cs_pipe;
         logic [STAGES-1:0] mo_pipe;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sck_pipe <= '0;
               cs_pipe  <= '1;
               mo_pipe  <= '0;
            end else begin
               sck_pipe <= {sck_pipe[STAGES-2:0], sck};
               cs_pipe  <= {cs_pipe[STAGES-2:0], csn};
               mo_pipe  <= {mo_pipe[STAGES-2:0], mosi};
            end
         end
         assign sck_s  = sck_pipe[STAGES-1];
         assign s_cs   = cs_pipe[STAGES-1];
         assign s_mosi = mo_pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sck_p <= 1'b0;
      else        sck_p <= sck_s;
   end

   assign rise = sck_s & ~sck_p & ~s_cs;
   assign fall = ~sck_s & sck_p & ~s_cs;

endmodule

// File: rtl/fcf_frame_ctl.sv
module fcf_frame_ctl
   import fcf_pkg::*;
#(
   parameter int ADDR_BYTES = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s_cs,
   input  logic                    s_mosi,
   input  logic                    rise,
   output cmd_e                    cmd_o,
   output logic                    cmd_valid,
   output logic [8*ADDR_BYTES-1:0] addr_o,
   output logic                    ph_strobe,
   output phase_e                  ph_kind,
   output logic [7:0]              rx_byte,
   output logic                    rd_req,
   output logic                    load_req,
   output logic                    out_is_id
);

   localparam int AW  = 8 * ADDR_BYTES;
   localparam int BCW = $clog2(ADDR_BYTES + 2);

   initial begin
      assert (ADDR_BYTES >= 1 && ADDR_BYTES <= 4)
         else $error("fcf_frame_ctl: ADDR_BYTES must be 1 to 4");
   end

   typedef enum logic [2:0] {
      ST_OPC, ST_ADDR, ST_DUM, ST_DOUT, ST_DIN, ST_DONE, ST_IGN
   } st_e;

   function automatic st_e tail_of(input shape_t s);
      if (s.streams)           return ST_DOUT;
      if (s.in_bytes != 2'd0)  return ST_DIN;
      return ST_DONE;
   endfunction

   st_e              state, nxt;
   logic [2:0]       bitcnt;
   logic [6:0]       sr;
   logic [BCW-1:0]   bcnt;
   cmd_e             cmd_q, new_cmd, cur_cmd;
   shape_t           shape_q, new_shape;
   logic [AW-1:0]    addr_q;
   logic [7:0]       byte_now;
   logic             byte_end;

   always_comb begin
      byte_now  = {sr, s_mosi};
      byte_end  = rise && (bitcnt == 3'd7);
      new_cmd   = op_decode(byte_now);
      new_shape = op_shape(new_cmd);
      cur_cmd   = (state == ST_OPC) ? new_cmd : cmd_q;
   end

   // state after the byte now completing
   always_comb begin
      nxt = state;
      unique case (state)
         ST_OPC:
            if (new_cmd == CMD_NONE)     nxt = ST_IGN;
            else if (new_shape.has_addr)  nxt = ST_ADDR;
            else if (new_shape.has_dummy) nxt = ST_DUM;
            else                          nxt = tail_of(new_shape);
         ST_ADDR:
            if (bcnt == BCW'(ADDR_BYTES - 1))
               nxt = shape_q.has_dummy ? ST_DUM : tail_of(shape_q);
         ST_DUM:
            nxt = tail_of(shape_q);
         ST_DIN:
            if (bcnt == BCW'(shape_q.in_bytes - 2'd1)) nxt = ST_DONE;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_OPC;
         bitcnt    <= '0;
         sr        <= '0;
         bcnt      <= '0;
         cmd_q     <= CMD_NONE;
         shape_q   <= '0;
         addr_q    <= '0;
         rx_byte   <= '0;
         ph_kind   <= PH_OPC;
         cmd_valid <= 1'b0;
         ph_strobe <= 1'b0;
         rd_req    <= 1'b0;
         load_req  <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         ph_strobe <= 1'b0;
         rd_req    <= 1'b0;
         load_req  <= 1'b0;
         if (s_cs) begin
            state  <= ST_OPC;
            bitcnt <= '0;
            bcnt   <= '0;
         end else if (rise) begin
            sr     <= byte_now[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (state == ST_ADDR) addr_q <= {addr_q[AW-2:0], s_mosi};
            if (byte_end) begin
               rx_byte  <= byte_now;
               state    <= nxt;
               bcnt     <= (nxt != state) ? '0 : bcnt + BCW'(1);
               load_req <= (nxt == ST_DOUT);
               rd_req   <= (nxt == ST_DOUT) && (cur_cmd != CMD_RDID);
               unique case (state)
                  ST_OPC: begin
                     cmd_q   <= new_cmd;
                     shape_q <= new_shape;
                     if (new_cmd != CMD_NONE) begin
                        cmd_valid <= 1'b1;
                        ph_strobe <= 1'b1;
                        ph_kind   <= PH_OPC;
                     end
                  end
                  ST_ADDR: begin
                     ph_strobe <= 1'b1;
                     ph_kind   <= PH_ADDR;
                  end
                  ST_DUM: begin
                     ph_strobe <= 1'b1;
                     ph_kind   <= PH_DUMMY;
                  end
                  ST_DOUT, ST_DIN: begin
                     ph_strobe <= 1'b1;
                     ph_kind   <= PH_DATA;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign cmd_o     = cmd_q;
   assign addr_o    = addr_q;
   assign out_is_id = (cmd_q == CMD_RDID);

   // R10
   ign_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGN) |=> (!ph_strobe && !cmd_valid && !load_req));

   // R11
   abort_to_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_cs |=> (state == ST_OPC && bitcnt == 3'd0));

   // R2
   valid_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_q != CMD_NONE));

   // R4
   strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_strobe |-> $past(rise));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_ADDR) |=> $stable(addr_q));

endmodule

// File: rtl/fcf_tx_shift.sv
module fcf_tx_shift #(
   parameter logic [7:0] MAN_ID       = 8'hA5,
   parameter logic [7:0] DEV_ID       = 8'h3C,
   parameter bit         ID_ALTERNATE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       s_cs,
   input  logic       fall,
   input  logic       load_req,
   input  logic       out_is_id,
   input  logic       id_a0,
   input  logic [7:0] rd_byte,
   output logic       miso,
   output logic       miso_oe
);

   logic [7:0] sh;
   logic       pend;
   logic       live;
   logic       first;
   logic       id_sel;
   logic       cur_sel;
   logic       nxt_sel;
   logic [7:0] src;

   always_comb begin
      cur_sel = first ? id_a0 : id_sel;
      src     = out_is_id ? (cur_sel ? DEV_ID : MAN_ID) : rd_byte;
   end

   generate
      if (ID_ALTERNATE) begin : g_alt
         assign nxt_sel = ~cur_sel;
      end else begin : g_fixed
         assign nxt_sel = cur_sel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh     <= '0;
         pend   <= 1'b0;
         live   <= 1'b0;
         first  <= 1'b1;
         id_sel <= 1'b0;
      end else if (s_cs) begin
         pend  <= 1'b0;
         live  <= 1'b0;
         first <= 1'b1;
      end else begin
         pend <= (pend && !fall) || load_req;
         if (fall) begin
            if (pend) begin
               sh     <= src;
               live   <= 1'b1;
               first  <= 1'b0;
               id_sel <= nxt_sel;
            end else begin
               sh <= {sh[6:0], 1'b0};
            end
         end
      end
   end

   assign miso    = sh[7];
   assign miso_oe = live & ~s_cs;

   // R5
   miso_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(miso));

   // R11
   oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_cs |=> !miso_oe);

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
   import fcf_pkg::*;
#(
   parameter int         ADDR_BYTES   = 3,
   parameter int         SYNC_STAGES  = 1,
   parameter logic [7:0] MAN_ID       = 8'hA5,
   parameter logic [7:0] DEV_ID       = 8'h3C,
   parameter bit         ID_ALTERNATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sck,
   input  logic                    csn,
   input  logic                    mosi,
   output logic                    miso,
   output logic                    miso_oe,
   output logic [3:0]              cmd_o,
   output logic                    cmd_valid,
   output logic [8*ADDR_BYTES-1:0] addr_o,
   output logic                    ph_strobe,
   output logic [1:0]              ph_kind,
   output logic [7:0]              rx_byte,
   output logic                    rd_req,
   input  logic [7:0]              rd_byte
);

   logic   s_cs, s_mosi, rise, fall;
   logic   load_req, out_is_id;
   cmd_e   cmd_w;
   phase_e kind_w;

   fcf_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck    (sck),
      .csn    (csn),
      .mosi   (mosi),
      .s_cs   (s_cs),
      .s_mosi (s_mosi),
      .rise   (rise),
      .fall   (fall)
   );

   fcf_frame_ctl #(.ADDR_BYTES(ADDR_BYTES)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_cs      (s_cs),
      .s_mosi    (s_mosi),
      .rise      (rise),
      .cmd_o     (cmd_w),
      .cmd_valid (cmd_valid),
      .addr_o    (addr_o),
      .ph_strobe (ph_strobe),
      .ph_kind   (kind_w),
      .rx_byte   (rx_byte),
      .rd_req    (rd_req),
      .load_req  (load_req),
      .out_is_id (out_is_id)
   );

   fcf_tx_shift #(
      .MAN_ID       (MAN_ID),
      .DEV_ID       (DEV_ID),
      .ID_ALTERNATE (ID_ALTERNATE)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_cs      (s_cs),
      .fall      (fall),
      .load_req  (load_req),
      .out_is_id (out_is_id),
      .id_a0     (addr_o[0]),
      .rd_byte   (rd_byte),
      .miso      (miso),
      .miso_oe   (miso_oe)
   );

   assign cmd_o   = cmd_w;
   assign ph_kind = kind_w;

endmodule

// File: tb/sim_flash_cmd_frontend.sv
module sim_flash_cmd_frontend;

   localparam int CLK_P = 10;
   localparam int HALF  = 4;
   localparam int NV    = 14;

   // opcode, cmd, address bytes, dummy bytes, data strobes, output mode (0 none, 1 back end, 2 id)
   localparam logic [20:0] VEC [NV] = '{
      {8'h03, 4'd1,  2'd3, 2'd0, 3'd3, 2'd1},
      {8'h0B, 4'd2,  2'd3, 2'd1, 3'd2, 2'd1},
      {8'h05, 4'd3,  2'd0, 2'd0, 3'd6, 2'd1},
      {8'h9F, 4'd4,  2'd0, 2'd0, 3'd6, 2'd1},
      {8'h90, 4'd5,  2'd3, 2'd0, 3'd3, 2'd2},
      {8'hAB, 4'd5,  2'd3, 2'd0, 3'd3, 2'd2},
      {8'h20, 4'd6,  2'd3, 2'd0, 3'd0, 2'd0},
      {8'h52, 4'd7,  2'd3, 2'd0, 3'd0, 2'd0},
      {8'hD8, 4'd8,  2'd3, 2'd0, 3'd0, 2'd0},
      {8'h60, 4'd9,  2'd0, 2'd0, 3'd0, 2'd0},
      {8'hC7, 4'd9,  2'd0, 2'd0, 3'd0, 2'd0},
      {8'h02, 4'd10, 2'd3, 2'd0, 3'd1, 2'd0},
      {8'hAD, 4'd11, 2'd3, 2'd0, 3'd2, 2'd0},
      {8'hFF, 4'd0,  2'd0, 2'd0, 3'd0, 2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0;
   logic        csn = 1'b1;
   logic        mosi = 1'b0;
   logic        miso, miso_oe, cmd_valid, ph_strobe, rd_req;
   logic [3:0]  cmd_o;
   logic [23:0] addr_o;
   logic [1:0]  ph_kind;
   logic [7:0]  rx_byte;
   logic [7:0]  rd_byte = 8'h00;
   logic [7:0]  rd_seq = 8'h00;

   int n_tests = 0;
   int n_fail  = 0;
   int n_ph [4];
   int n_valid = 0;
   int n_oe    = 0;
   logic [7:0] last_wr = 8'h00;

   logic [7:0] txb [8];
   logic [7:0] rxb [8];

   always #(CLK_P/2) clk = ~clk;

   flash_cmd_frontend u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck       (sck),
      .csn       (csn),
      .mosi      (mosi),
      .miso      (miso),
      .miso_oe   (miso_oe),
      .cmd_o     (cmd_o),
      .cmd_valid (cmd_valid),
      .addr_o    (addr_o),
      .ph_strobe (ph_strobe),
      .ph_kind   (ph_kind),
      .rx_byte   (rx_byte),
      .rd_req    (rd_req),
      .rd_byte   (rd_byte)
   );

   // back-end byte supply
   always @(posedge clk) begin
      if (rd_req) begin
         rd_byte <= 8'hC0 + rd_seq;
         rd_seq  <= rd_seq + 8'd1;
      end
   end

   initial for (int k = 0; k < 4; k++) n_ph[k] = 0;

   always @(negedge clk) begin
      if (ph_strobe) begin
         n_ph[ph_kind] = n_ph[ph_kind] + 1;
         if (ph_kind == 2'd3) last_wr = rx_byte;
      end
      if (cmd_valid) n_valid = n_valid + 1;
      if (miso_oe) n_oe = n_oe + 1;
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int c);
      case (c)
         1:       return "R5";
         2:       return "R6";
         3, 4:    return "R7";
         5:       return "R8";
         0:       return "R10";
         default: return "R9";
      endcase
   endfunction

   task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] r);
      r = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = b[i];
         repeat (HALF) @(negedge clk);
         r[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic run_frame(input int n);
      csn = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) xfer(txb[i], 8, rxb[i]);
      repeat (HALF) @(negedge clk);
      csn = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [20:0] e;
      logic [7:0]  opc, seq0, expb, tmp;
      int c, na, nd, ndat, om, st;
      int s_ph [4];
      int s_val, s_oe;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      chk("R1", "miso_oe", miso_oe, 0);
      chk("R1", "cmd_o", cmd_o, 0);
      chk("R1", "strobes", n_ph[0] + n_ph[1] + n_ph[2] + n_ph[3], 0);
      chk("R1", "cmd_valid", n_valid, 0);

      txb[1] = 8'h12; txb[2] = 8'h34; txb[3] = 8'h57;
      txb[4] = 8'hA1; txb[5] = 8'hA2; txb[6] = 8'hA3;

      for (int v = 0; v < NV; v++) begin
         e    = VEC[v];
         opc  = e[20:13];
         c    = int'(e[12:9]);
         na   = int'(e[8:7]);
         nd   = int'(e[6:5]);
         ndat = int'(e[4:2]);
         om   = int'(e[1:0]);
         txb[0] = opc;
         for (int k = 0; k < 4; k++) s_ph[k] = n_ph[k];
         s_val = n_valid;
         s_oe  = n_oe;
         seq0  = rd_seq;
         run_frame(7);
         chk("R2", $sformatf("cmd for %0h", opc), cmd_o, c);
         chk("R2", $sformatf("cmd_valid for %0h", opc), n_valid - s_val, (c != 0) ? 1 : 0);
         chk("R4", $sformatf("command strobe for %0h", opc), n_ph[0] - s_ph[0], (c != 0) ? 1 : 0);
         chk("R3", $sformatf("address strobes for %0h", opc), n_ph[1] - s_ph[1], na);
         chk(tag_of(c), $sformatf("dummy strobes for %0h", opc), n_ph[2] - s_ph[2], nd);
         chk(tag_of(c), $sformatf("data strobes for %0h", opc), n_ph[3] - s_ph[3], ndat);
         chk(tag_of(c), $sformatf("output enable for %0h", opc), (n_oe - s_oe) > 0 ? 1 : 0,
             (om != 0) ? 1 : 0);
         st = 1 + na + nd;
         if (om != 0) begin
            for (int i = st; i < 7; i++) begin
               if (om == 1) expb = 8'hC0 + seq0 + 8'(i - st);
               else         expb = (((i - st) % 2) == 0) ? 8'h3C : 8'hA5;
               chk(tag_of(c), $sformatf("out byte %0d for %0h", i - st, opc), rxb[i], expb);
            end
         end
         if (om == 0 && ndat > 0)
            chk("R9", $sformatf("written byte for %0h", opc), last_wr, txb[st + ndat - 1]);
      end

      // R3 address held after the ignored frame
      chk("R3", "addr_o", addr_o, 24'h123457);

      // R8 id read with A0 = 0
      txb[0] = 8'h90; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
      run_frame(7);
      chk("R8", "id byte 0 (A0=0)", rxb[4], 8'hA5);
      chk("R8", "id byte 1 (A0=0)", rxb[5], 8'h3C);
      chk("R8", "id byte 2 (A0=0)", rxb[6], 8'hA5);

      // R11 abort in the middle of a command byte, then a status read
      for (int k = 0; k < 4; k++) s_ph[k] = n_ph[k];
      csn = 1'b0;
      repeat (HALF) @(negedge clk);
      xfer(8'h0B, 4, tmp);
      repeat (HALF) @(negedge clk);
      csn = 1'b1;
      repeat (6) @(negedge clk);
      chk("R11", "oe after abort", miso_oe, 0);
      seq0 = rd_seq;
      txb[0] = 8'h05;
      run_frame(3);
      chk("R11", "cmd after abort", cmd_o, 3);
      chk("R11", "command strobes", n_ph[0] - s_ph[0], 1);
      chk("R11", "address strobes", n_ph[1] - s_ph[1], 0);
      chk("R7", "first status byte", rxb[1], 8'hC0 + seq0);
      chk("R7", "second status byte", rxb[2], 8'hC1 + seq0);
      chk("R11", "oe after frame", miso_oe, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule